// File: doc/BRIEF.md
# Nonvolatile Shadow SRAM Controller

This block models a byte-wide static memory in which every location has a nonvolatile twin. It also contains the controller that moves the whole image between the two arrays. In normal use it behaves like an asynchronous-read SRAM with a clocked write. The pins are active-low chip enable, output enable and write enable, an address bus and a bidirectional data bus.

A nonvolatile-enable pin turns the control pins into transfer requests. A STORE copies the SRAM image into the shadow array. A RECALL copies the shadow array back into the SRAM. A transfer starts only when the pins move into the request combination. Once started, it runs for a fixed number of clocks and finishes even if the pins go idle. While it runs, the memory ignores its pins and releases the data bus.

A synchronous supply-good flag drives the power behaviour. A rise of this flag starts an automatic restore, which is a RECALL with its own lockout length. A low flag blocks STOREs and cuts short a STORE that is already running.

Top module: `nvshadow_sram`

## Requirements
- R1: With nv_n high and ce_n low, we_n low writes dq into the addressed byte at the clock edge, and oe_n has no effect. With we_n high and oe_n low, the addressed byte is driven on dq with no clock delay.
- R2: The memory never drives dq while ce_n and we_n are both low. It also leaves dq high-impedance whenever it is not performing a read.
- R3: A STORE request is nv_n=0, ce_n=0, we_n=0, oe_n=1 with pwr_ok high. It starts a STORE only at the first clock edge where the combination appears, and busy is then high for exactly STORE_CYC clocks.
- R4: At its start, a STORE erases every shadow byte to 8'h00. At its end, it copies the complete SRAM image into the shadow array.
- R5: A RECALL request is nv_n=0, ce_n=0, we_n=1, oe_n=0. It starts a RECALL on a transition, and busy is then high for RECALL_CYC clocks. The SRAM is cleared at the start and loaded from the shadow array at the end, and the shadow array is left unchanged.
- R6: If the request pins are still held when a transfer ends, no second transfer starts.
- R7: While busy is high, writes are not applied, reads do not drive dq, and new requests are ignored.
- R8: After a transfer has started, it completes even if the control pins return to idle.
- R9: A low-to-high change of pwr_ok starts an automatic restore. busy is high for RESTORE_CYC clocks, and the SRAM is then loaded from the shadow array. A new restore needs pwr_ok to go low first.
- R10: A STORE request with pwr_ok low is inhibited. If pwr_ok falls during a STORE, busy drops at the next edge and the shadow array stays erased (all 8'h00).
- R11: With nv_n low, no SRAM read or write takes place for any pin combination.
- R12: During reset busy is low. After reset it stays low while pwr_ok stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile transfer enable, active low |
| pwr_ok | input | 1 | Supply above threshold, synchronous |
| addr | input | AW | Byte address |
| dq | inout | WIDTH | Bidirectional data |
| busy | output | 1 | Transfer or restore lockout running |

## Verification
A wrong transfer state shows at the ports within one clock. busy would rise or fall on the wrong edge, or dq would be driven or released against the pin decode in that same cycle. A wrong copy between the arrays stays hidden until a later read. Because of this, every transfer is followed by reads of the boundary addresses and of overwritten bytes. The reference model compares busy and dq at every clock.

// File: rtl/nvshadow_sram.sv
`timescale 1ns/1ps
module nvshadow_sram #(
  parameter int DEPTH       = 2048,
  parameter int WIDTH       = 8,
  parameter int STORE_CYC   = 64,
  parameter int RECALL_CYC  = 16,
  parameter int RESTORE_CYC = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ?
                        ((STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC) :
                        ((RECALL_CYC > RESTORE_CYC) ? RECALL_CYC : RESTORE_CYC),
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             nv_n,
  input  logic             pwr_ok,
  input  logic [AW-1:0]    addr,
  inout  wire  [WIDTH-1:0] dq,
  output logic             busy
);

  typedef enum logic [1:0] {IDLE, STORE, RECALL, RESTORE} mode_t;

  mode_t          mode;
  logic [CW-1:0]  cnt;
  logic           st_prev, rc_prev, pw_prev;
  logic [WIDTH-1:0] sram [DEPTH];
  logic [WIDTH-1:0] nv   [DEPTH];

  logic st_req, rc_req, wr_en, rd_en, pw_rise;

  assign st_req  = !ce_n && !nv_n && !we_n && oe_n;
  assign rc_req  = !ce_n && !nv_n && we_n && !oe_n;
  assign wr_en   = !ce_n && nv_n && !we_n;
  assign rd_en   = !busy && !ce_n && nv_n && we_n && !oe_n;
  assign pw_rise = pwr_ok && !pw_prev;
  assign busy    = (mode != IDLE);
  assign dq      = rd_en ? sram[addr] : {WIDTH{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= IDLE;
      cnt     <= '0;
      st_prev <= 1'b0;
      rc_prev <= 1'b0;
      pw_prev <= 1'b0;
    end else begin
      st_prev <= st_req;
      rc_prev <= rc_req;
      pw_prev <= pwr_ok;
      if (pw_rise) begin
        mode <= RESTORE;
        cnt  <= CW'(RESTORE_CYC - 1);
        for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
      end else if (mode == STORE && !pwr_ok) begin
        mode <= IDLE;
        cnt  <= '0;
      end else if (mode != IDLE) begin
        if (cnt == '0) begin
          mode <= IDLE;
          if (mode == STORE) for (int i = 0; i < DEPTH; i++) nv[i] <= sram[i];
          else               for (int i = 0; i < DEPTH; i++) sram[i] <= nv[i];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (st_req && !st_prev && pwr_ok) begin
        mode <= STORE;
        cnt  <= CW'(STORE_CYC - 1);
        for (int i = 0; i < DEPTH; i++) nv[i] <= '0;
      end else if (rc_req && !rc_prev) begin
        mode <= RECALL;
        cnt  <= CW'(RECALL_CYC - 1);
        for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
      end else if (wr_en) begin
        sram[addr] <= dq;
      end
    end
  end

  assert_store_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDLE && st_req && !st_prev && pwr_ok && !pw_rise) |=> (mode == STORE && busy));

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDLE && st_req && st_prev && !pw_rise) |=> !busy);

  assert_runs_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !pw_rise && !(mode == STORE && !pwr_ok)) |=> (busy && $stable(mode)));

  assert_powerup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pw_rise |=> (mode == RESTORE && busy));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == STORE && !pwr_ok) |=> !busy);

endmodule

// File: tb/test_nvshadow_sram.sv
`timescale 1ns/1ps
module test_nvshadow_sram;
  localparam int DEPTH = 2048, WIDTH = 8;
  localparam int ST = 20, RC = 12, RS = 16;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, nv_n = 1, pwr_ok = 0;
  logic [10:0] addr = '0;
  logic [7:0]  tb_d = '0;
  logic        tb_drv = 0;
  wire  [7:0]  dq;
  logic        busy;
  int errors = 0, checks = 0;
  string tag = "R7";
  bit started = 0;

  assign dq = tb_drv ? tb_d : 8'bz;
  always #2.5 clk = ~clk;

  nvshadow_sram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STORE_CYC(ST), .RECALL_CYC(RC),
                  .RESTORE_CYC(RS)) i_nvshadow_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
    .pwr_ok(pwr_ok), .addr(addr), .dq(dq), .busy(busy));

  // behavioural reference model
  byte unsigned m_sram [DEPTH];
  byte unsigned m_nv   [DEPTH];
  bit  m_sk [DEPTH];
  bit  m_nk [DEPTH];
  int  m_left = 0, m_kind = 0;
  bit  m_st = 0, m_rc = 0, m_pw = 0;

  always @(posedge clk) begin
    bit st, rc, wr;
    started = 1;
    st = !ce_n && !nv_n && !we_n && oe_n;
    rc = !ce_n && !nv_n && we_n && !oe_n;
    wr = !ce_n && nv_n && !we_n;
    if (!rst_n) begin
      m_left = 0; m_st = 0; m_rc = 0; m_pw = 0;
    end else begin
      if (pwr_ok && !m_pw) begin
        m_kind = 3; m_left = RS;
        foreach (m_sram[i]) begin m_sram[i] = 0; m_sk[i] = 1; end
      end else if (m_left > 0 && m_kind == 1 && !pwr_ok) begin
        m_left = 0;
      end else if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_kind == 1) foreach (m_nv[i]) begin m_nv[i] = m_sram[i]; m_nk[i] = m_sk[i]; end
          else foreach (m_sram[i]) begin m_sram[i] = m_nv[i]; m_sk[i] = m_nk[i]; end
        end
      end else if (st && !m_st && pwr_ok) begin
        m_kind = 1; m_left = ST;
        foreach (m_nv[i]) begin m_nv[i] = 0; m_nk[i] = 1; end
      end else if (rc && !m_rc) begin
        m_kind = 2; m_left = RC;
        foreach (m_sram[i]) begin m_sram[i] = 0; m_sk[i] = 1; end
      end else if (wr) begin
        m_sram[addr] = tb_d; m_sk[addr] = tb_drv;
      end
      m_st = st; m_rc = rc; m_pw = pwr_ok;
    end
  end

  always @(negedge clk) if (started) begin
    checks++;
    if (busy !== (m_left > 0)) begin
      errors++;
      $display("FAIL %s busy actual=%b expected=%b", tag, busy, m_left > 0);
    end
    if (m_left == 0 && !ce_n && nv_n && we_n && !oe_n) begin
      if (m_sk[addr]) begin
        checks++;
        if (dq !== m_sram[addr]) begin
          errors++;
          $display("FAIL R1 read @%0d actual=%h expected=%h", addr, dq, m_sram[addr]);
        end
      end
    end else if (!tb_drv) begin
      checks++;
      if (dq !== 8'bz) begin
        errors++;
        $display("FAIL R2 dq driven actual=%h expected=zz", dq);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; nv_n = 1; tb_drv = 0;
  endtask

  task automatic wr(int a, int d, bit oe = 1);
    ce_n = 0; nv_n = 1; we_n = 0; oe_n = oe; addr = 11'(a); tb_d = 8'(d); tb_drv = 1;
    cyc(1); idle();
  endtask

  task automatic rd(string r, int a, int exp);
    ce_n = 0; nv_n = 1; we_n = 1; oe_n = 0; addr = 11'(a);
    @(negedge clk); #0.1;
    chk(r, dq, exp);
    @(posedge clk); #1; idle();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; cyc(1); end
  endtask

  task automatic store_req();
    ce_n = 0; nv_n = 0; we_n = 0; oe_n = 1; tb_drv = 0;
  endtask

  task automatic recall_req();
    ce_n = 0; nv_n = 0; we_n = 1; oe_n = 0; tb_drv = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    idle();
    cyc(3);
    tag = "R12"; chk("R12 busy in reset", busy, 0);
    rst_n = 1; cyc(3);
    chk("R12 busy after reset, supply low", busy, 0);

    tag = "R9"; pwr_ok = 1; cyc(1);
    chk("R9 restore starts", busy, 1);
    ce_n = 0; nv_n = 1; we_n = 1; oe_n = 0; addr = 5;   // R7 read blocked
    wait_idle(n); idle();
    chk("R9 restore length", n, RS);
    cyc(3); chk("R9 no rerun while high", busy, 0);

    tag = "R1";
    wr(0, 'h11); wr(2047, 'hEE); wr(5, 'hA5); wr(100, 'h3C, 0);
    rd("R1 addr0", 0, 'h11); rd("R1 addr2047", 2047, 'hEE);
    rd("R1 write precedence", 100, 'h3C); rd("R1 addr5", 5, 'hA5);

    tag = "R3"; store_req(); cyc(1);
    chk("R3 store starts", busy, 1);
    tag = "R7"; wr(5, 'h00);
    tag = "R8"; wait_idle(n);
    chk("R8 store completes after release", n, ST - 1);
    rd("R7 write ignored during store", 5, 'hA5);

    tag = "R1"; wr(0, 'h77); wr(5, 'h55); rd("R1 overwrite", 0, 'h77);

    tag = "R5"; recall_req(); cyc(1);
    wait_idle(n);
    chk("R5 recall length", n, RC);
    tag = "R6"; cyc(5);
    chk("R6 no retrigger while held", busy, 0);
    idle();
    tag = "R5";
    rd("R5 recall addr0", 0, 'h11); rd("R4 stored addr5", 5, 'hA5);
    rd("R4 stored addr2047", 2047, 'hEE); rd("R4 stored addr100", 100, 'h3C);

    tag = "R11";
    ce_n = 0; nv_n = 0; we_n = 0; oe_n = 0; addr = 5; tb_d = 'h99; tb_drv = 1;
    cyc(2); chk("R11 no transfer", busy, 0);
    idle(); ce_n = 0; nv_n = 0; we_n = 1; oe_n = 1; addr = 5;
    @(negedge clk); #0.1; chk("R11 no read drive", (dq === 8'bz), 1);
    @(posedge clk); #1; idle();
    rd("R11 write blocked", 5, 'hA5);

    tag = "R10"; pwr_ok = 0; cyc(1);
    store_req(); cyc(2);
    chk("R10 store inhibited", busy, 0);
    idle(); wr(0, 'h42);
    tag = "R9"; pwr_ok = 1; cyc(1);
    chk("R9 rearmed restore", busy, 1);
    wait_idle(n);
    rd("R10 nv unchanged by inhibited store", 0, 'h11);

    tag = "R10"; wr(0, 'h42);
    store_req(); cyc(1); idle(); cyc(3);
    pwr_ok = 0; cyc(1);
    chk("R10 store aborted", busy, 0);
    pwr_ok = 1; cyc(1); wait_idle(n);
    rd("R10 erased addr0", 0, 'h00); rd("R10 erased addr2047", 2047, 'h00);

    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule